// File: doc/BRIEF.md
# Adaptive Cache Bypass Controller

This block decides, for every cache miss, whether the incoming line is placed in the cache or skipped entirely. The chance of skipping is a power of two, 2^-k. The block holds it as an exponent k and compares the low k bits of a pseudo-random register against zero. The exponent starts at 6, which is 1/64. It can climb to a configurable floor exponent (8 by default). One step past the floor is a special "off" code, where the probability is zero.

The block learns from the results of its own decisions. After a real bypass, it remembers two things. One is a 16-bit partial tag of the skipped line. The other is the 4-bit way of the resident line that the skipped line would have displaced. The block then watches the access stream.

- If the skipped line comes back as a miss first, bypassing was a mistake. The probability is halved.
- If the protected resident line is hit first, bypassing paid off. The probability is doubled.

Either outcome clears the record. A newer bypass simply replaces a record that has not yet resolved.

While the probability is zero, the block still samples misses at 1/16. It creates "virtual" records that never assert the bypass output. This lets the exponent recover from the off state. The choice of victim way and all data movement belong to the surrounding cache.

Top module: `adaptive_bypass_ctrl`

## Requirements
- R1: After reset, `prob_exp_o` is 6, no record is pending, and the pseudo-random register holds 16'hACE1.
- R2: `bypass_o` depends combinationally on the current access. It can be 1 only in a cycle with `acc_valid_i`=1 and `acc_hit_i`=0. A hit or an idle cycle always gives 0.
- R3: The pseudo-random register is a 16-bit shift register. Its next value is {s[14:0], s[15]^s[13]^s[12]^s[10]}. It advances only on the clock edge that ends a miss cycle. On a miss with exponent k in 0..8, `bypass_o` is 1 exactly when bits [k-1:0] of the current register are all zero. At k=0 it is always 1.
- R4: Exponent code 9 means probability zero. With that code, `bypass_o` stays 0 on every miss.
- R5: With exponent code 9, a miss whose register bits [15:12] are all zero creates a virtual record (the partial tag and the victim way). `bypass_o` stays 0, and the record resolves like a real one.
- R6: Every real or virtual bypass stores `acc_ptag_i` and `victim_way_i` as the pending record. It replaces any record already pending.
- R7: A miss whose partial tag equals the pending record's tag raises the exponent by one at the next edge and clears the record. Code 8 becomes 9, and code 9 stays 9.
- R8: A hit whose way equals the pending record's way lowers the exponent by one at the next edge and clears the record. Code 0 stays 0, and code 9 becomes 8.
- R9: When a miss both resolves the pending record (R7) and triggers a new bypass, the decision uses the exponent held before that edge. The new record replaces the cleared one.
- R10: Misses that match no record, hits on other ways, and idle cycles leave the exponent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_hit_i | input | 1 | 1 = access hit, 0 = access missed |
| acc_ptag_i | input | 16 | Partial tag of the accessed line |
| acc_way_i | input | 4 | Way that hit (used when `acc_hit_i`=1) |
| victim_way_i | input | 4 | Way the cache would replace on this miss |
| bypass_o | output | 1 | Skip allocation for the current miss |
| prob_exp_o | output | 4 | Current exponent k (probability 2^-k); 9 = zero |

## Verification
Two functions can land on the same miss:
- resolving a pending record because the missing tag matches it, and
- a fresh bypass decision, which may start a new record.

The bench provokes this by reissuing the tracked tag as a miss while the exponent is low, where bypasses are frequent. It judges the result in two ways. The `bypass_o` value must follow the pre-edge exponent. The exponent seen in the next cycle must be one higher. The bench then issues a hit on the new victim way, which must move the exponent back. This shows that the replacement record took effect rather than the cleared one.

// File: rtl/acb_pkg.sv
package acb_pkg;
   // outcome of comparing one access against the pending record
   typedef enum logic [1:0] {
      FB_NONE  = 2'd0,
      FB_SLOWER = 2'd1,   // skipped line came back first: halve probability
      FB_FASTER = 2'd2    // protected resident hit first: double probability
   } fb_e;
endpackage

// File: rtl/acb_lfsr.sv
module acb_lfsr #(
   parameter int          WIDTH = 16,
   parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             adv_i,
   output logic [WIDTH-1:0] state_o
);
   logic             fb;
   logic [WIDTH-1:0] state_q;

   generate
      if (WIDTH == 16) begin : g_w16
         assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
      end else if (WIDTH == 32) begin : g_w32
         assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
      end else begin : g_bad
         $error("acb_lfsr: WIDTH must be 16 or 32");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    state_q <= SEED[WIDTH-1:0];
      else if (adv_i) state_q <= {state_q[WIDTH-2:0], fb};
   end

   assign state_o = state_q;

   AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != '0);  // R3
endmodule

// File: rtl/acb_decide.sv
module acb_decide #(
   parameter int LFSR_W   = 16,
   parameter int EXP_W    = 4,
   parameter int OFF_CODE = 9,
   parameter int VIRT_EXP = 4
) (
   input  logic [LFSR_W-1:0] rnd_i,
   input  logic [EXP_W-1:0]  exp_i,
   input  logic              miss_i,
   output logic              fire_real_o,
   output logic              fire_virt_o
);
   logic [LFSR_W-1:0] mask;
   logic              is_off;

   always_comb begin
      for (int i = 0; i < LFSR_W; i++) begin
         mask[i] = (i < int'(exp_i));
      end
   end

   assign is_off      = (int'(exp_i) == OFF_CODE);
   assign fire_real_o = miss_i && !is_off && ((rnd_i & mask) == '0);
   assign fire_virt_o = miss_i &&  is_off && (rnd_i[LFSR_W-1 -: VIRT_EXP] == '0);
endmodule

// File: rtl/acb_ladder.sv
module acb_ladder
   import acb_pkg::*;
#(
   parameter int EXP_W    = 4,
   parameter int INIT_EXP = 6,
   parameter int FLOOR_EXP = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  fb_e              fb_i,
   output logic [EXP_W-1:0] exp_o
);
   localparam logic [EXP_W-1:0] OFF   = EXP_W'(FLOOR_EXP + 1);
   localparam logic [EXP_W-1:0] FLOOR = EXP_W'(FLOOR_EXP);

   logic [EXP_W-1:0] exp_q, exp_d;

   always_comb begin
      exp_d = exp_q;
      unique case (fb_i)
         FB_SLOWER: exp_d = (exp_q >= FLOOR) ? OFF : exp_q + 1'b1;
         FB_FASTER: begin
            if (exp_q == OFF)        exp_d = FLOOR;
            else if (exp_q != '0)    exp_d = exp_q - 1'b1;
         end
         default:   exp_d = exp_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) exp_q <= EXP_W'(INIT_EXP);
      else         exp_q <= exp_d;
   end

   assign exp_o = exp_q;

   AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exp_q <= OFF);  // R4
   AST_EXP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fb_i == FB_NONE |=> $stable(exp_q));  // R10
endmodule

// File: rtl/acb_track.sv
module acb_track #(
   parameter int TAG_W = 16,
   parameter int WAY_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             load_virt_i,
   input  logic [TAG_W-1:0] load_tag_i,
   input  logic [WAY_W-1:0] load_way_i,
   input  logic             clear_i,
   output logic             valid_o,
   output logic             virt_o,
   output logic [TAG_W-1:0] tag_o,
   output logic [WAY_W-1:0] way_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         virt_o  <= 1'b0;
         tag_o   <= '0;
         way_o   <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         virt_o  <= load_virt_i;
         tag_o   <= load_tag_i;
         way_o   <= load_way_i;
      end else if (clear_i) begin
         valid_o <= 1'b0;
         virt_o  <= 1'b0;
      end
   end

   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> valid_o && tag_o == $past(load_tag_i));  // R6
endmodule

// File: rtl/adaptive_bypass_ctrl.sv
module adaptive_bypass_ctrl
   import acb_pkg::*;
#(
   parameter int TAG_W     = 16,
   parameter int WAY_W     = 4,
   parameter int LFSR_W    = 16,
   parameter int INIT_EXP  = 6,
   parameter int FLOOR_EXP = 8,
   parameter int VIRT_EXP  = 4,
   localparam int EXP_W    = $clog2(FLOOR_EXP + 2)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             acc_valid_i,
   input  logic             acc_hit_i,
   input  logic [TAG_W-1:0] acc_ptag_i,
   input  logic [WAY_W-1:0] acc_way_i,
   input  logic [WAY_W-1:0] victim_way_i,
   output logic             bypass_o,
   output logic [EXP_W-1:0] prob_exp_o
);
   localparam int OFF_CODE = FLOOR_EXP + 1;

   generate
      if (INIT_EXP > FLOOR_EXP)   begin : g_chk_init  $error("INIT_EXP above FLOOR_EXP"); end
      if (FLOOR_EXP > LFSR_W)     begin : g_chk_floor $error("FLOOR_EXP wider than LFSR"); end
      if (VIRT_EXP < 1 || VIRT_EXP > LFSR_W) begin : g_chk_virt $error("VIRT_EXP out of range"); end
   endgenerate

   logic              miss, hit;
   logic [LFSR_W-1:0] rnd;
   logic              fire_real, fire_virt;
   logic              rec_valid, rec_virt;
   logic [TAG_W-1:0]  rec_tag;
   logic [WAY_W-1:0]  rec_way;
   logic              seen_skipped, seen_resident;
   fb_e               fb;

   assign miss = acc_valid_i && !acc_hit_i;
   assign hit  = acc_valid_i &&  acc_hit_i;

   acb_lfsr #(.WIDTH(LFSR_W), .SEED(32'h0000_ACE1)) u_lfsr (
      .clk_i, .rst_ni, .adv_i(miss), .state_o(rnd));

   acb_decide #(.LFSR_W(LFSR_W), .EXP_W(EXP_W), .OFF_CODE(OFF_CODE),
                .VIRT_EXP(VIRT_EXP)) u_decide (
      .rnd_i(rnd), .exp_i(prob_exp_o), .miss_i(miss),
      .fire_real_o(fire_real), .fire_virt_o(fire_virt));

   assign seen_skipped  = rec_valid && miss && (acc_ptag_i == rec_tag);
   assign seen_resident = rec_valid && hit  && (acc_way_i  == rec_way);
   assign fb = seen_skipped  ? FB_SLOWER :
               seen_resident ? FB_FASTER : FB_NONE;

   acb_ladder #(.EXP_W(EXP_W), .INIT_EXP(INIT_EXP), .FLOOR_EXP(FLOOR_EXP)) u_ladder (
      .clk_i, .rst_ni, .fb_i(fb), .exp_o(prob_exp_o));

   acb_track #(.TAG_W(TAG_W), .WAY_W(WAY_W)) u_track (
      .clk_i, .rst_ni,
      .load_i(fire_real || fire_virt), .load_virt_i(fire_virt),
      .load_tag_i(acc_ptag_i), .load_way_i(victim_way_i),
      .clear_i(seen_skipped || seen_resident),
      .valid_o(rec_valid), .virt_o(rec_virt), .tag_o(rec_tag), .way_o(rec_way));

   assign bypass_o = fire_real;

   AST_MISS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bypass_o |-> miss);  // R2
   AST_FULL_PROB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (miss && prob_exp_o == '0) |-> bypass_o);  // R3
   AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(prob_exp_o) == OFF_CODE) |-> !bypass_o);  // R4
   AST_VIRT_AT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rec_valid && rec_virt) |-> int'(prob_exp_o) == OFF_CODE);  // R5
   AST_SLOWER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_skipped && int'(prob_exp_o) != OFF_CODE) |=> prob_exp_o == $past(prob_exp_o) + 1'b1);  // R7
   AST_FASTER_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_resident && prob_exp_o != '0) |=> prob_exp_o != $past(prob_exp_o));  // R8
endmodule

// File: tb/adaptive_bypass_ctrl_tb.sv
`timescale 1ns/1ps
module adaptive_bypass_ctrl_tb;
   localparam int OFF = 9;
   localparam int FLOOR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v = 1'b0, h = 1'b0;
   logic [15:0] tag = '0;
   logic [3:0]  way = '0, vic = '0;
   logic        byp;
   logic [3:0]  pexp;

   int vectors = 0, miscompares = 0;

   // bench reference state
   logic [15:0] m_rnd;
   int          m_exp;
   bit          m_val;
   logic [15:0] m_tag;
   logic [3:0]  m_way;
   string       prev_lbl = "R1";

   always #4 clk = ~clk;  // 125 MHz

   adaptive_bypass_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_hit_i(h),
      .acc_ptag_i(tag), .acc_way_i(way), .victim_way_i(vic),
      .bypass_o(byp), .prob_exp_o(pexp));

   function automatic logic [15:0] rnd_next(logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic bit exp_fire(logic [15:0] s, int k);
      logic [15:0] msk = 16'((32'd1 << k) - 1);
      if (k == OFF) return 1'b0;
      return (s & msk) == 16'h0;
   endfunction

   task automatic check(string lbl, int act, int expv);
      vectors++;
      if (act != expv) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", lbl, act, expv, $time);
      end
   endtask

   task automatic step(bit iv, bit ih, logic [15:0] it, logic [3:0] iw, logic [3:0] ivic);
      bit miss, lose, win, fr, fvir;
      string bl;
      @(negedge clk);
      v = iv; h = ih; tag = it; way = iw; vic = ivic;
      #1;
      miss = iv && !ih;
      lose = m_val && miss && (it == m_tag);
      win  = m_val && iv && ih && (iw == m_way);
      fr   = miss && exp_fire(m_rnd, m_exp);
      fvir = miss && (m_exp == OFF) && (m_rnd[15:12] == 4'h0);
      bl = !miss ? "R2 hit or idle" : (m_exp == OFF) ? (fvir ? "R5 virtual" : "R4 off") : "R3 draw";
      check(bl, int'(byp), int'(fr));
      check(prev_lbl, int'(pexp), m_exp);
      // advance the reference to the state after this edge
      if (lose) begin
         m_exp = (m_exp >= FLOOR) ? OFF : m_exp + 1;
         prev_lbl = (fr || fvir) ? "R9 resolve plus new bypass" : "R7 skipped line returned";
      end else if (win) begin
         m_exp = (m_exp == OFF) ? FLOOR : (m_exp == 0) ? 0 : m_exp - 1;
         prev_lbl = "R8 resident hit";
      end else prev_lbl = "R10 no feedback";
      if (fr || fvir) begin
         m_val = 1'b1; m_tag = it; m_way = ivic;   // R6
      end else if (lose || win) m_val = 1'b0;
      if (miss) m_rnd = rnd_next(m_rnd);
   endtask

   initial begin
      #(8 * 200000);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed);
      m_rnd = 16'hACE1; m_exp = 6; m_val = 1'b0; m_tag = '0; m_way = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1 reset exponent", int'(pexp), 6);
      check("R1 reset no bypass", int'(byp), 0);
      // directed: hits never bypass and do not move anything without a record
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 16'(i), 4'(i), 4'(i));
      // directed: idle cycles
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 16'h0, 4'h0, 4'h0);
      // phases: 0 favours resident hits (toward exponent 0),
      // 1 favours skipped-line returns (toward off), 2 mixed
      for (int ph = 0; ph < 6; ph++) begin
         for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            int bias = (ph % 3 == 0) ? 40 : (ph % 3 == 1) ? 5 : 15;
            int lbias = (ph % 3 == 1) ? 40 : (ph % 3 == 0) ? 5 : 15;
            logic [3:0] rv = 4'($urandom_range(0, 15));
            if (m_val && r < bias)
               step(1'b1, 1'b1, 16'($urandom_range(0, 7)), m_way, rv);
            else if (m_val && r < bias + lbias)
               step(1'b1, 1'b0, m_tag, 4'($urandom_range(0, 15)), rv);
            else if (r < 90)
               step(1'b1, r[0], 16'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), rv);
            else
               step(1'b0, 1'b0, 16'h0, 4'h0, rv);
         end
      end
      step(1'b0, 1'b0, 16'h0, 4'h0, 4'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule